// File: doc/BRIEF.md
# Microwire Serial Memory Word Reader

This block is a bus master that fetches one 16-bit word from a serial memory that uses the Microwire framing. It uses four pins: a select line, a serial clock, a data line towards the memory and a data line back from it. A request gives a byte address and a one-cycle start strobe. The block first adds a fixed user-area offset to the byte address and halves the sum to form the word address. It then raises select and shifts out a 13-bit read frame. After the frame it clocks in sixteen data bits and drops every pin low again.

All pin activity is paced by one "step", a fixed number of system clocks set by a parameter. A read is made of 89 steps: one select setup step, three steps per command bit, three steps per data bit and one release step. Software-free hardware, such as a boot loader or a configuration fetcher, can use the block by pulsing start and waiting for the done pulse. The word is presented on the result bus in the cycle of that pulse.

Top module: `mwire_word_reader`

## Requirements
- R1: A start accepted while idle raises eeCs with eeSck and eeMosi both low, and this state holds for one step before the first command bit is set up. The first rising eeSck therefore comes exactly 3*HOLD_CYCLES cycles after eeCs rises.
- R2: The command frame is 13 bits long and is sent most significant bit first. Its three leading bits are 1, 1, 0, and its last 10 bits are the word address.
- R3: The word address is bits [10:1] of (byteAddr + 0x100). The sum is taken one bit wider than byteAddr, so the word address wraps modulo 1024.
- R4: Each command bit follows the same three-step pattern. First eeMosi takes the new bit while eeSck is low. Next comes a step with eeSck low, then a step with eeSck high. eeMosi never changes while eeSck is high, and eeSck is never high while eeCs is low.
- R5: After the frame, 16 further eeSck pulses are issued. eeMiso is sampled at the end of each high step and shifted in MSB first, so the bit present during the 14th rising edge of the transaction becomes wordOut[15].
- R6: After the last data bit, eeCs, eeSck and eeMosi all go low together and stay low for one step before done is raised. All three pins stay low whenever busy is low.
- R7: Every step lasts HOLD_CYCLES clock cycles. A start strobe sampled at clock edge E0 gives done at edge E0 + 89*HOLD_CYCLES.
- R8: busy rises in the cycle after a start is accepted and stays high for exactly 89*HOLD_CYCLES cycles. It falls in the cycle in which done is high. done is a one-cycle pulse, and wordOut holds the fetched word during that pulse.
- R9: A start strobe that arrives while busy is high is ignored. It changes neither the frame in progress nor the result, and it produces no extra done pulse.
- R10: While rstN is low and after it rises, eeCs, eeSck, eeMosi, busy and done are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to read a word, accepted only when idle |
| byteAddr | input | BYTE_ADDR_W (11) | Byte address within the user area |
| busy | output | 1 | High while a read is in progress |
| done | output | 1 | One-cycle pulse marking a finished read |
| wordOut | output | DATA_W (16) | Fetched word, valid when done is high |
| eeCs | output | 1 | Chip select to the serial memory |
| eeSck | output | 1 | Serial clock to the serial memory |
| eeMosi | output | 1 | Serial data to the memory |
| eeMiso | input | 1 | Serial data from the memory |

## Verification
The bench builds the block with HOLD_CYCLES = 2 and the default widths and offset. With this value a whole read takes 178 cycles, which leaves room for many reads: odd and even byte addresses, the highest word address, and the wrap of the address sum. Because each step is two cycles long, the fixed delays can be told apart from off-by-one variants. Those delays are select-to-first-clock, release-to-done and start-to-done. A bench memory model answers on the pins and returns an address-dependent pattern. A data bit taken on the wrong edge, or a word address formed wrongly, therefore shows up as a mismatched word or frame.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  // Leading frame bits: start bit followed by the two-bit read opcode
  localparam int unsigned READ_PREFIX_W = 3;
  localparam logic [READ_PREFIX_W-1:0] READ_PREFIX = 3'b110;

  // Sequencer states, one per kind of timed step
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SELECT,
    ST_CMD_SETUP,
    ST_CMD_LOW,
    ST_CMD_HIGH,
    ST_DAT_LOW,
    ST_DAT_HIGH,
    ST_DAT_POST,
    ST_RELEASE
  } mwrState_e;

  // Strobes from control to datapath, raised for one cycle at a step boundary
  typedef struct packed {
    logic loadCmd;   // latch frame, raise select, park clock and data low
    logic nextBit;   // put next frame bit on the data line, clock low
    logic sckLow;    // drive clock low
    logic sckHigh;   // drive clock high
    logic sampleIn;  // shift the returned data bit in
    logic allLow;    // drop select, clock and data
    logic finish;    // publish the result and pulse done
  } mwrStrobe_t;

endpackage

// File: rtl/mwr_step_timer.sv
module mwr_step_timer #(
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  output logic expired
);

  generate
    if (HOLD_CYCLES <= 1) begin : g_single
      // Every step is one cycle long: the step always ends at the next edge
      logic unusedTimerIn;
      assign unusedTimerIn = ^{clk, rstN, restart};
      assign expired = 1'b1;
    end else begin : g_count
      localparam int unsigned TMR_W = $clog2(HOLD_CYCLES);
      localparam logic [TMR_W-1:0] RELOAD = TMR_W'(HOLD_CYCLES - 1);

      logic [TMR_W-1:0] remain;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          remain <= '0;
        end else if (restart) begin
          remain <= RELOAD;
        end else if (remain != '0) begin
          remain <= remain - 1'b1;
        end
      end

      assign expired = (remain == '0);
    end
  endgenerate

endmodule

// File: rtl/mwr_ctrl.sv
module mwr_ctrl
  import mwr_pkg::*;
#(
  parameter int unsigned CMD_LEN = 13,
  parameter int unsigned DATA_W  = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       stepDone,
  output mwrStrobe_t strb,
  output logic       busy
);

  localparam int unsigned MAX_LEN   = (CMD_LEN > DATA_W) ? CMD_LEN : DATA_W;
  localparam int unsigned CNT_W     = $clog2(MAX_LEN);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_LEN - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  mwrState_e        state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;

  always_comb begin
    stateNext  = state;
    bitCntNext = bitCnt;
    strb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stateNext    = ST_SELECT;
          strb.loadCmd = 1'b1;
          bitCntNext   = '0;
        end
      end
      ST_SELECT: begin
        if (stepDone) begin
          stateNext    = ST_CMD_SETUP;
          strb.nextBit = 1'b1;
        end
      end
      ST_CMD_SETUP: begin
        if (stepDone) begin
          stateNext   = ST_CMD_LOW;
          strb.sckLow = 1'b1;
        end
      end
      ST_CMD_LOW: begin
        if (stepDone) begin
          stateNext    = ST_CMD_HIGH;
          strb.sckHigh = 1'b1;
        end
      end
      ST_CMD_HIGH: begin
        if (stepDone) begin
          if (bitCnt == CMD_LAST) begin
            stateNext   = ST_DAT_LOW;
            strb.sckLow = 1'b1;
            bitCntNext  = '0;
          end else begin
            stateNext    = ST_CMD_SETUP;
            strb.nextBit = 1'b1;
            bitCntNext   = bitCnt + 1'b1;
          end
        end
      end
      ST_DAT_LOW: begin
        if (stepDone) begin
          stateNext    = ST_DAT_HIGH;
          strb.sckHigh = 1'b1;
        end
      end
      ST_DAT_HIGH: begin
        if (stepDone) begin
          stateNext     = ST_DAT_POST;
          strb.sampleIn = 1'b1;
        end
      end
      ST_DAT_POST: begin
        if (stepDone) begin
          if (bitCnt == DATA_LAST) begin
            stateNext   = ST_RELEASE;
            strb.allLow = 1'b1;
          end else begin
            stateNext   = ST_DAT_LOW;
            strb.sckLow = 1'b1;
            bitCntNext  = bitCnt + 1'b1;
          end
        end
      end
      ST_RELEASE: begin
        if (stepDone) begin
          stateNext   = ST_IDLE;
          strb.finish = 1'b1;
        end
      end
      default: begin
        stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/mwr_datapath.sv
module mwr_datapath
  import mwr_pkg::*;
#(
  parameter int unsigned BYTE_ADDR_W = 11,
  parameter int unsigned WORD_ADDR_W = 10,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned HOLD_CYCLES = 4,
  parameter int unsigned USER_OFFSET = 256
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [BYTE_ADDR_W-1:0] byteAddr,
  input  logic                   miso,
  input  mwrStrobe_t             strb,
  output logic                   stepDone,
  output logic                   cs,
  output logic                   sck,
  output logic                   mosi,
  output logic [DATA_W-1:0]      result,
  output logic                   done
);

  localparam int unsigned CMD_LEN = READ_PREFIX_W + WORD_ADDR_W;
  localparam int unsigned SUM_W   = BYTE_ADDR_W + 1;

  logic [SUM_W-1:0]       offsetAddr;
  logic [WORD_ADDR_W-1:0] wordAddr;
  logic [CMD_LEN-1:0]     cmdShift;
  logic [DATA_W-1:0]      dataShift;
  logic                   stepRestart;

  // Byte address moved into the user area, then halved to a word address
  assign offsetAddr = {1'b0, byteAddr} + SUM_W'(USER_OFFSET);
  assign wordAddr   = offsetAddr[WORD_ADDR_W:1];

  // Every pin-changing strobe opens a new timed step
  assign stepRestart = strb.loadCmd | strb.nextBit | strb.sckLow |
                       strb.sckHigh | strb.sampleIn | strb.allLow;

  mwr_step_timer #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_stepTimer (
    .clk    (clk),
    .rstN   (rstN),
    .restart(stepRestart),
    .expired(stepDone)
  );

  // Frame shifter and pin drivers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdShift <= '0;
      cs       <= 1'b0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
    end else begin
      if (strb.loadCmd) begin
        cmdShift <= {READ_PREFIX, wordAddr};
        cs       <= 1'b1;
        sck      <= 1'b0;
        mosi     <= 1'b0;
      end
      if (strb.nextBit) begin
        mosi     <= cmdShift[CMD_LEN-1];
        cmdShift <= {cmdShift[CMD_LEN-2:0], 1'b0};
        sck      <= 1'b0;
      end
      if (strb.sckLow) begin
        sck <= 1'b0;
      end
      if (strb.sckHigh) begin
        sck <= 1'b1;
      end
      if (strb.allLow) begin
        cs   <= 1'b0;
        sck  <= 1'b0;
        mosi <= 1'b0;
      end
    end
  end

  // Returned data shifter, result register and completion pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataShift <= '0;
      result    <= '0;
      done      <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.sampleIn) begin
        dataShift <= {dataShift[DATA_W-2:0], miso};
      end
      if (strb.finish) begin
        result <= dataShift;
      end
    end
  end

endmodule

// File: rtl/mwire_word_reader.sv
module mwire_word_reader
  import mwr_pkg::*;
#(
  parameter int unsigned BYTE_ADDR_W = 11,
  parameter int unsigned WORD_ADDR_W = 10,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned HOLD_CYCLES = 4,
  parameter int unsigned USER_OFFSET = 256
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [BYTE_ADDR_W-1:0] byteAddr,
  output logic                   busy,
  output logic                   done,
  output logic [DATA_W-1:0]      wordOut,
  output logic                   eeCs,
  output logic                   eeSck,
  output logic                   eeMosi,
  input  logic                   eeMiso
);

  localparam int unsigned CMD_LEN = READ_PREFIX_W + WORD_ADDR_W;

  mwrStrobe_t strb;
  logic       stepDone;

  mwr_ctrl #(
    .CMD_LEN(CMD_LEN),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .stepDone(stepDone),
    .strb    (strb),
    .busy    (busy)
  );

  mwr_datapath #(
    .BYTE_ADDR_W(BYTE_ADDR_W),
    .WORD_ADDR_W(WORD_ADDR_W),
    .DATA_W     (DATA_W),
    .HOLD_CYCLES(HOLD_CYCLES),
    .USER_OFFSET(USER_OFFSET)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .byteAddr(byteAddr),
    .miso    (eeMiso),
    .strb    (strb),
    .stepDone(stepDone),
    .cs      (eeCs),
    .sck     (eeSck),
    .mosi    (eeMosi),
    .result  (wordOut),
    .done    (done)
  );

endmodule

// File: rtl/mwr_checker.sv
module mwr_checker #(
  parameter int unsigned HOLD_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic eeCs,
  input logic eeSck,
  input logic eeMosi
);

  // Cycles for which select has been high, saturating
  int unsigned csAge;

  always_ff @(posedge clk) begin
    if (!rstN || !eeCs) begin
      csAge <= 0;
    end else if (csAge < 32'd1000000) begin
      csAge <= csAge + 1;
    end
  end

  AST_CS_RISES_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeCs) |-> (!eeSck && !eeMosi)); // R1

  AST_SELECT_SETUP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeSck) |-> (csAge >= HOLD_CYCLES)); // R1

  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    eeSck |-> eeCs); // R4

  AST_MOSI_STILL_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    eeSck |-> $stable(eeMosi)); // R4

  AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!eeCs && !eeSck && !eeMosi)); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R8

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R8

  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done)); // R8

endmodule

bind mwire_word_reader mwr_checker #(
  .HOLD_CYCLES(HOLD_CYCLES)
) u_checker (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .eeCs  (eeCs),
  .eeSck (eeSck),
  .eeMosi(eeMosi)
);

// File: tb/mwire_word_reader_bench.sv
`timescale 1ns/1ps
module mwire_word_reader_bench;

  localparam int HOLD     = 2;
  localparam int BAW      = 11;
  localparam int WAW      = 10;
  localparam int DW       = 16;
  localparam int OFS      = 256;
  localparam int CMD_BITS = 3 + WAW;
  localparam int STEPS    = 1 + 3 * CMD_BITS + 3 * DW + 1;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [BAW-1:0] byteAddr = '0;
  logic           busy, done, eeCs, eeSck, eeMosi;
  logic [DW-1:0]  wordOut;
  logic           miso = 1'b0;

  mwire_word_reader #(
    .BYTE_ADDR_W(BAW),
    .WORD_ADDR_W(WAW),
    .DATA_W     (DW),
    .HOLD_CYCLES(HOLD),
    .USER_OFFSET(OFS)
  ) u_mwire_word_reader (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .byteAddr(byteAddr),
    .busy    (busy),
    .done    (done),
    .wordOut (wordOut),
    .eeCs    (eeCs),
    .eeSck   (eeSck),
    .eeMosi  (eeMosi),
    .eeMiso  (miso)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [DW-1:0]       word;
    logic [CMD_BITS-1:0] frame;
    int                  startCyc;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  int issued = 0;
  int doneCnt = 0;

  // Serial memory model state
  logic                prevCs = 1'b0, prevSck = 1'b0, prevMosi = 1'b0;
  int                  riseCnt = 0, csRiseCyc = 0, csFallCyc = 0, lastRises = 0;
  logic [CMD_BITS-1:0] frameBits = '0, lastFrame = '0;
  logic [DW-1:0]       memData = '0;
  int                  busyLen = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int wordOf(input int a);
    return ((a + OFS) >> 1) & ((1 << WAW) - 1);
  endfunction

  function automatic logic [DW-1:0] memWord(input int w);
    return DW'((w * 40503) ^ 32'hC3A5 ^ (w << 6));
  endfunction

  function automatic logic [CMD_BITS-1:0] frameOf(input int w);
    return CMD_BITS'((3'b110 << WAW) | w);
  endfunction

  // Memory model on the pins: captures the frame, answers with data
  initial begin
    forever begin
      @(negedge clk);
      if (eeCs && !prevCs) begin
        check(!eeSck && !eeMosi, "R1", "clock/data at select rise", {eeSck, eeMosi}, 0);
        riseCnt   = 0;
        frameBits = '0;
        csRiseCyc = cyc;
      end
      if (eeCs && eeSck && !prevSck) begin
        riseCnt++;
        check(eeMosi == prevMosi, "R4", "data moved at clock rise", eeMosi, prevMosi);
        if (riseCnt == 1)
          check(cyc - csRiseCyc == 3 * HOLD, "R1", "select to first clock", cyc - csRiseCyc, 3 * HOLD);
        if (riseCnt <= CMD_BITS) frameBits = {frameBits[CMD_BITS-2:0], eeMosi};
        if (riseCnt == CMD_BITS) memData = memWord(int'(frameBits[WAW-1:0]));
        if (riseCnt > CMD_BITS && riseCnt <= CMD_BITS + DW)
          miso = memData[DW - 1 - (riseCnt - CMD_BITS - 1)];
      end
      if (!eeCs && prevCs) begin
        csFallCyc = cyc;
        lastRises = riseCnt;
        lastFrame = frameBits;
      end
      prevCs   = eeCs;
      prevSck  = eeSck;
      prevMosi = eeMosi;
    end
  end

  // Scoreboard monitor: pops one expected item per done pulse
  initial begin
    expItem_t e;
    forever begin
      @(negedge clk);
      if (busy) busyLen++;
      if (done) begin
        doneCnt++;
        if (expQ.size() == 0) begin
          check(1'b0, "R9", "done with nothing requested", 1, 0);
        end else begin
          e = expQ.pop_front();
          check(wordOut == e.word, "R5", "fetched word", wordOut, e.word);
          check(lastFrame == e.frame, "R2", "command frame", lastFrame, e.frame);
          check(lastFrame[WAW-1:0] == e.frame[WAW-1:0], "R3", "word address", lastFrame[WAW-1:0], e.frame[WAW-1:0]);
          check(lastRises == CMD_BITS + DW, "R5", "clock pulse count", lastRises, CMD_BITS + DW);
          check(cyc - e.startCyc == STEPS * HOLD + 1, "R7", "start to done", cyc - e.startCyc, STEPS * HOLD + 1);
          check(cyc - csFallCyc == HOLD, "R6", "release step length", cyc - csFallCyc, HOLD);
          check(!eeCs && !eeSck && !eeMosi, "R6", "pins at done", {eeCs, eeSck, eeMosi}, 0);
          check(!busy && busyLen == STEPS * HOLD, "R8", "busy length", busyLen, STEPS * HOLD);
        end
        busyLen = 0;
      end
    end
  end

  task automatic doRead(input int a);
    expItem_t e;
    @(negedge clk);
    start    = 1'b1;
    byteAddr = BAW'(a);
    e.word     = memWord(wordOf(a));
    e.frame    = frameOf(wordOf(a));
    e.startCyc = cyc;
    expQ.push_back(e);
    issued++;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8", "busy after start", busy, 1);
  endtask

  task automatic waitIdle();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    check(!done, "R8", "done is a single pulse", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check({eeCs, eeSck, eeMosi, busy, done} == 5'b0, "R10", "outputs in reset", {eeCs, eeSck, eeMosi, busy, done}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check({eeCs, eeSck, eeMosi, busy, done} == 5'b0, "R10", "outputs after reset", {eeCs, eeSck, eeMosi, busy, done}, 0);

    doRead(0);     waitIdle();   // even address, low user area
    doRead(1);     waitIdle();   // odd byte shares the word of its even neighbour
    doRead(12'h2FE); waitIdle(); // mid range
    doRead(12'h6FE); waitIdle(); // highest word address
    doRead(12'h7FF); waitIdle(); // R3 wrap of the offset sum
    doRead(12'h155); waitIdle();

    // R9: a second start during a read must be ignored
    doRead(12'h0AA);
    repeat (20) @(negedge clk);
    start    = 1'b1;
    byteAddr = BAW'(12'h3C4);
    @(negedge clk);
    start = 1'b0;
    waitIdle();
    repeat (30) @(negedge clk);
    check(doneCnt == issued, "R9", "done count", doneCnt, issued);

    doRead(12'h3C4); waitIdle();   // back-to-back read after the ignored start
    repeat (5) @(negedge clk);
    check(doneCnt == issued, "R9", "final done count", doneCnt, issued);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule